// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block turns a fast source clock into two slower clocks for a processor subsystem. A static strap chooses the source: the crystal oscillator signal or an external frequency input. The selected source is divided by three into a processor clock that is high for one source period out of every three. The processor clock is then divided by two into a peripheral clock with equal high and low times. The oscillator signal is also brought straight out on its own pin, so it can serve as an independent clock even when the external input runs the divider.

Several of these generators can be made to share one phase. An alignment clear input stops the divider while it is held. When it is released, every generator restarts from the same count. The clear passes through a two-flop synchronizer clocked by the external frequency input before it reaches the divider. An active-high reset clears the synchronizer, the counter and both clock outputs.

Top module: `tri_clkgen`

## Requirements
- R1: The processor clock `cpu_clk` repeats every 3 source cycles and is high for exactly 1 of them, so its duty cycle is 33%.
- R2: After the internal clear drops, the first source edge moves the counter from 0 to 1. `cpu_clk` first rises on the third source edge after that internal clear drops.
- R3: `align_clr` reaches the divider through exactly two flip-flops clocked by `ext_clk`. The divider still counts on the first two `ext_clk` edges after `align_clr` rises, and is cleared from the third.
- R4: While the synchronized clear is high, the counter stays at 0 and both `cpu_clk` and `per_clk` are held low.
- R5: `per_clk` toggles on every falling transition of `cpu_clk` and starts low after a clear or reset. Its period is 6 source cycles with 3 high and 3 low.
- R6: `src_strap` = 1 clocks the divider from `ext_clk`, and `src_strap` = 0 clocks it from `osc_in`. The strap is only changed while reset is held.
- R7: `osc_out` always equals `osc_in`, whichever source the strap selects.
- R8: While `rst` is high, `cpu_clk` and `per_clk` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_in | input | 1 | Oscillator signal, one candidate source |
| ext_clk | input | 1 | External frequency input; also clocks the clear synchronizer |
| src_strap | input | 1 | Static source select: 1 selects ext_clk, 0 selects osc_in |
| rst | input | 1 | Active-high asynchronous reset |
| align_clr | input | 1 | Phase-alignment clear, asynchronous to the divider |
| osc_out | output | 1 | Buffered copy of osc_in |
| cpu_clk | output | 1 | Source divided by three, 33% duty |
| per_clk | output | 1 | cpu_clk divided by two, 50% duty |

## Verification
The hardest case to reach from the ports is the two-stage latency of the clear. Its effect only shows when the clear rises at an edge where the divider is about to produce a processor pulse. The stimulus first releases the clear at a known external-clock edge, which puts the counter phase in a known state. It then counts external edges and raises the clear again one edge before a pulse is due. A correct design still shows that pulse and then goes low; a design with a shorter synchronizer would suppress the pulse. The oscillator source is checked separately, by sampling the outputs on oscillator edges while the external clock runs at an unrelated rate.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
   typedef enum logic {
      SRC_OSC = 1'b0,
      SRC_EXT = 1'b1
   } src_e;
endpackage

// File: rtl/clkgen_src_sel.sv
module clkgen_src_sel
   import clkgen_pkg::*;
(
   input  logic osc_in,
   input  logic ext_in,
   input  src_e sel,
   output logic src_clk
);
   // strap is static; it may change only while the divider is in reset
   always_comb begin
      src_clk = (sel == SRC_EXT) ? ext_in : osc_in;
   end
endmodule

// File: rtl/clkgen_clr_sync.sv
module clkgen_clr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkgen_clr_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkgen_div.sv
module clkgen_div #(
   parameter int DIV   = 3,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             pulse
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else if (clr) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else begin
         cnt   <= (cnt == LAST) ? '0 : cnt + ONE;
         pulse <= (cnt == LAST);
      end
   end
endmodule

// File: rtl/clkgen_half.sv
module clkgen_half (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic pulse,
   output logic half
);
   // pulse is one source cycle wide, so pulse==1 at an edge means it falls there
   always_ff @(posedge clk or posedge rst) begin
      if (rst)        half <= 1'b0;
      else if (clr)   half <= 1'b0;
      else if (pulse) half <= ~half;
   end
endmodule

// File: rtl/tri_clkgen.sv
module tri_clkgen
   import clkgen_pkg::*;
#(
   parameter int DIV         = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic osc_in,
   input  logic ext_clk,
   input  logic src_strap,
   input  logic rst,
   input  logic align_clr,
   output logic osc_out,
   output logic cpu_clk,
   output logic per_clk
);
   localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

   generate
      if (DIV < 3) begin : g_bad_div
         $error("tri_clkgen: DIV must be at least 3");
      end
   endgenerate

   src_e             sel;
   logic             src_clk;
   logic             clr_s;
   logic [CNT_W-1:0] cnt;

   assign sel     = src_e'(src_strap);
   assign osc_out = osc_in;

   clkgen_src_sel u_sel (
      .osc_in  (osc_in),
      .ext_in  (ext_clk),
      .sel     (sel),
      .src_clk (src_clk)
   );

   clkgen_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (ext_clk),
      .rst (rst),
      .d   (align_clr),
      .q   (clr_s)
   );

   clkgen_div #(.DIV(DIV), .CNT_W(CNT_W)) u_div (
      .clk   (src_clk),
      .rst   (rst),
      .clr   (clr_s),
      .cnt   (cnt),
      .pulse (cpu_clk)
   );

   clkgen_half u_half (
      .clk   (src_clk),
      .rst   (rst),
      .clr   (clr_s),
      .pulse (cpu_clk),
      .half  (per_clk)
   );
endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk #(
   parameter int CNT_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input logic             src_clk,
   input logic             ext_clk,
   input logic             rst,
   input logic             align_clr,
   input logic             clr_s,
   input logic [CNT_W-1:0] cnt,
   input logic             cpu_clk,
   input logic             per_clk
);
   // R1: a processor pulse lasts one source cycle
   p_cpu_narrow_r1: assert property (@(posedge src_clk) disable iff (rst)
      cpu_clk |=> !cpu_clk);

   // R1: at least two low cycles precede every high cycle
   p_cpu_gap_r1: assert property (@(posedge src_clk) disable iff (rst)
      cpu_clk |-> (!$past(cpu_clk) && !$past(cpu_clk, 2)));

   // R2: counting restarts from zero after the internal clear drops
   p_restart_r2: assert property (@(posedge src_clk) disable iff (rst)
      $fell(clr_s) |=> (cnt == CNT_W'(1)));

   // R3: two-stage latency of the alignment clear
   generate
      if (SYNC_STAGES == 2) begin : g_lat
         p_sync_lat_r3: assert property (@(posedge ext_clk) disable iff (rst)
            clr_s == $past(align_clr, 2));
      end
   endgenerate

   // R4: both outputs low after a cleared edge
   p_clr_hold_r4: assert property (@(posedge src_clk) disable iff (rst)
      $past(clr_s) |-> (!cpu_clk && !per_clk));

   // R5: peripheral clock flips where the processor clock falls
   p_per_flip_r5: assert property (@(posedge src_clk) disable iff (rst)
      ($past(cpu_clk) && !$past(clr_s)) |-> (per_clk != $past(per_clk)));

   // R5: peripheral clock holds elsewhere
   p_per_hold_r5: assert property (@(posedge src_clk) disable iff (rst)
      (!$past(cpu_clk) && !$past(clr_s)) |-> $stable(per_clk));
endmodule

bind tri_clkgen clkgen_chk #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .src_clk   (src_clk),
   .ext_clk   (ext_clk),
   .rst       (rst),
   .align_clr (align_clr),
   .clr_s     (clr_s),
   .cnt       (cnt),
   .cpu_clk   (cpu_clk),
   .per_clk   (per_clk)
);

// File: tb/sim_tri_clkgen.sv
`timescale 1ns/100ps
module sim_tri_clkgen;
   logic ext_clk   = 1'b0;
   logic osc_in    = 1'b0;
   logic rst       = 1'b1;
   logic src_strap = 1'b1;
   logic align_clr = 1'b0;
   logic osc_out, cpu_clk, per_clk;

   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #2.5 ext_clk = ~ext_clk;   // 200 MHz
   always #4   osc_in  = ~osc_in;    // unrelated oscillator rate

   tri_clkgen u0 (
      .osc_in    (osc_in),
      .ext_clk   (ext_clk),
      .src_strap (src_strap),
      .rst       (rst),
      .align_clr (align_clr),
      .osc_out   (osc_out),
      .cpu_clk   (cpu_clk),
      .per_clk   (per_clk)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // expected {cpu,per} after the j-th counting edge since clear release;
   // clear reasserted so that edge jclr+2 is the first cleared one
   function automatic logic [1:0] model(input int j, input int jclr);
      logic c, p;
      if (j < 1 || j > jclr + 1) return 2'b00;
      c = (j >= 3) && (j % 3 == 0);
      p = (((j - 1) / 3) % 2) == 1;
      return {c, p};
   endfunction

   // scoreboard monitor: compares one queued item per external-clock period
   always @(negedge ext_clk) begin
      if (exp_q.size() > 0) begin
         logic [1:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check({cpu_clk, per_clk} == e, t, "{cpu,per}",
               int'({cpu_clk, per_clk}), int'(e));
      end
   end

   task automatic push(input logic [1:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : driver
      localparam int JCLR = 20;
      // ---------------- external source ----------------
      repeat (4) @(negedge ext_clk);
      #1;
      check(!cpu_clk && !per_clk, "R8", "outputs in reset",
            int'({cpu_clk, per_clk}), 0);
      check(osc_out == osc_in, "R7", "osc_out ext mode", osc_out, osc_in);
      rst = 1'b0;
      repeat (10) @(negedge ext_clk);
      #1;
      align_clr = 1'b1;
      repeat (4) @(negedge ext_clk);
      #1;
      for (int i = 0; i < 6; i++) push(2'b00, "R4");
      repeat (7) @(negedge ext_clk);
      #1;
      check(osc_out == osc_in, "R7", "osc_out ext mode", osc_out, osc_in);
      // release: first pop follows edge B (j=-1), all R1/R2/R3/R5
      align_clr = 1'b0;
      for (int j = -1; j <= JCLR + 5; j++) begin
         if (j == JCLR + 1)      push(model(j, JCLR), "R3");
         else if (j <= 0)        push(model(j, JCLR), "R2");
         else if (j > JCLR + 1)  push(model(j, JCLR), "R4");
         else                    push(model(j, JCLR), "R1_R5");
      end
      repeat (JCLR + 1) @(negedge ext_clk);
      #1;
      align_clr = 1'b1;
      while (exp_q.size() > 0) @(negedge ext_clk);
      // ---------------- oscillator source ----------------
      #1;
      rst = 1'b1;
      align_clr = 1'b0;
      src_strap = 1'b0;
      repeat (3) @(negedge osc_in);
      #1;
      check(!cpu_clk && !per_clk, "R8", "outputs in reset",
            int'({cpu_clk, per_clk}), 0);
      rst = 1'b0;
      repeat (12) @(negedge osc_in);
      begin
         logic c[30];
         logic p[30];
         int   highs, bad_gap, bad_per, flips;
         highs = 0; bad_gap = 0; bad_per = 0; flips = 0;
         for (int i = 0; i < 30; i++) begin
            @(negedge osc_in);
            c[i] = cpu_clk;
            p[i] = per_clk;
            if (i == 5) check(osc_out == osc_in, "R7", "osc_out osc mode", osc_out, osc_in);
         end
         for (int i = 0; i < 30; i++) begin
            if (c[i]) highs++;
            if (i >= 3 && c[i] && (!c[i-3] || c[i-1] || c[i-2])) bad_gap++;
            if (i >= 1 && p[i] != p[i-1]) begin
               flips++;
               if (!c[i-1]) bad_per++;
            end
         end
         check(highs == 10, "R6", "cpu highs in 30 osc cycles", highs, 10);
         check(bad_gap == 0, "R1", "cpu spacing on osc", bad_gap, 0);
         check(bad_per == 0, "R5", "per flip without cpu fall", bad_per, 0);
         check(flips >= 9, "R5", "per flips in 30 osc cycles", flips, 9);
      end
      #1;
      align_clr = 1'b1;
      repeat (10) @(negedge osc_in);
      for (int i = 0; i < 5; i++) begin
         @(negedge osc_in);
         check(!cpu_clk && !per_clk, "R4", "held on osc source",
               int'({cpu_clk, per_clk}), 0);
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule